// File: doc/BRIEF.md
# CSR Access Permission Checker

This block rules on every control-and-status-register instruction issued by a single-issue pipeline. It takes the 12-bit register address, the kind of access (read, write, or a read-set/read-clear with a flag saying whether the source operand is zero) and a one-bit answer from an external table saying whether the address is backed by a real register. It returns, one clock later, either a grant or an illegal-instruction exception request.

No per-register attribute table is kept. Writability and the minimum privilege both come from fixed fields of the address. The two top bits mark a read-only register when both are set. The next two bits name the lowest privilege level allowed in. The block also holds the hart's current privilege level in a register that the pipeline reloads on trap entry or return. That register starts in Machine mode.

Top module: `csr_perm_check`

## Requirements
- R1: After reset, `grant_o` and `illegal_o` are 0 and `cur_priv_o` is 3 (Machine).
- R2: When `valid_i` is 0, or when neither `rd_en_i` nor `wr_en_i` is set, both `grant_o` and `illegal_o` are 0 in the following cycle.
- R3: Privilege is encoded 0 = User, 1 = Supervisor, 2 = reserved, 3 = Machine. An access whose current privilege is numerically below address bits [9:8] raises `illegal_o` one cycle later.
- R4: An access to an implemented address with current privilege at or above address bits [9:8], and no write to a read-only register, raises `grant_o` one cycle later.
- R5: Address bits [11:10] equal to 2'b11 mark a read-only register. An effective write to such an address raises `illegal_o`. Values 0 to 2 in that field permit writes.
- R6: When `setclr_i` is 1 and `src_zero_i` is 1, a write request counts as a read only. Such an access to a read-only register is granted.
- R7: An access with `impl_i` = 0 raises `illegal_o` regardless of privilege or access type.
- R8: `grant_o` and `illegal_o` are never both 1.
- R9: When `priv_load_i` is 1, `cur_priv_o` takes `priv_next_i` at the next edge. An access issued in the same cycle is judged against the old level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | A CSR instruction is presented this cycle |
| csr_addr_i | input | 12 | CSR address |
| rd_en_i | input | 1 | Instruction reads the register |
| wr_en_i | input | 1 | Instruction requests a write |
| setclr_i | input | 1 | Write is a read-set or read-clear form |
| src_zero_i | input | 1 | Source operand of the instruction is zero |
| impl_i | input | 1 | Address is backed by an implemented register |
| priv_load_i | input | 1 | Reload the current privilege level |
| priv_next_i | input | 2 | New privilege level |
| cur_priv_o | output | 2 | Current privilege level |
| grant_o | output | 1 | Access may proceed (registered) |
| illegal_o | output | 1 | Illegal-instruction request (registered) |

## Verification
The bench builds the block with its defaults: a 12-bit address and a registered verdict (`REG_OUT` = 1). With those values, both address fields sit at the positions the requirements name, so the bench can sweep all sixteen pairings of current privilege and minimum privilege, including the reserved level 2. The one-cycle latency also lets the bench show that a privilege reload in the same cycle as an access leaves that access judged against the previous level.

// File: rtl/csr_perm_pkg.sv
// Shared types for the CSR permission checker.
// Assumes a two-bit privilege code in which a larger value means more privilege.
package csr_perm_pkg;
    typedef enum logic [1:0] {
        LVL_USER  = 2'd0,
        LVL_SUPER = 2'd1,
        LVL_RSVD  = 2'd2,
        LVL_MACH  = 2'd3
    } lvl_e;

    typedef struct packed {
        logic grant;
        logic illegal;
    } verdict_t;
endpackage

// File: rtl/csr_field_decode.sv
// Splits a CSR address into its writability field and its minimum-privilege field.
// Assumes the two fields are the top four address bits: access class above, level below.
module csr_field_decode #(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]       addr_i,
    output logic                    read_only_o,
    output csr_perm_pkg::lvl_e      min_lvl_o
);
    localparam int CLASS_HI = ADDR_W - 1;
    localparam int CLASS_LO = ADDR_W - 2;
    localparam int LVL_HI   = ADDR_W - 3;
    localparam int LVL_LO   = ADDR_W - 4;

    // Decode the access class and minimum level from the address.
    always_comb begin
        read_only_o = &addr_i[CLASS_HI:CLASS_LO];
        min_lvl_o   = csr_perm_pkg::lvl_e'(addr_i[LVL_HI:LVL_LO]);
    end
endmodule

// File: rtl/csr_verdict.sv
// Combinational grant/illegal decision for one CSR access.
// Assumes the caller qualifies the access with valid; the verdict is all-zero when idle.
module csr_verdict (
    input  logic                    valid_i,
    input  logic                    rd_en_i,
    input  logic                    wr_en_i,
    input  logic                    setclr_i,
    input  logic                    src_zero_i,
    input  logic                    impl_i,
    input  logic                    read_only_i,
    input  csr_perm_pkg::lvl_e      min_lvl_i,
    input  csr_perm_pkg::lvl_e      cur_lvl_i,
    output csr_perm_pkg::verdict_t  verdict_o
);
    logic access;
    logic eff_write;
    logic too_low;
    logic fault;

    // Classify the access and combine the three reasons for a fault.
    always_comb begin
        access    = valid_i && (rd_en_i || wr_en_i);
        eff_write = wr_en_i && !(setclr_i && src_zero_i);
        too_low   = cur_lvl_i < min_lvl_i;
        fault     = !impl_i || too_low || (eff_write && read_only_i);
        verdict_o.grant   = access && !fault;
        verdict_o.illegal = access && fault;
    end
endmodule

// File: rtl/csr_priv_state.sv
// Holds the hart's current privilege level and reloads it on request.
// Assumes synchronous active-low reset, which puts the hart in Machine mode.
module csr_priv_state (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [1:0]          next_i,
    output csr_perm_pkg::lvl_e  lvl_o
);
    // Privilege register: Machine at reset, new level when load is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_o <= csr_perm_pkg::LVL_MACH;
        end else if (load_i) begin
            lvl_o <= csr_perm_pkg::lvl_e'(next_i);
        end
    end
endmodule

// File: rtl/csr_perm_check.sv
// Top of the CSR permission checker: decodes the address fields, judges the access
// against the held privilege level and presents the verdict. REG_OUT = 1 registers
// the verdict for one cycle of latency; 0 presents it combinationally.
// Assumes impl_i is the lookup result for csr_addr_i in the same cycle.
module csr_perm_check #(
    parameter int ADDR_W  = 12,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [ADDR_W-1:0] csr_addr_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic              setclr_i,
    input  logic              src_zero_i,
    input  logic              impl_i,
    input  logic              priv_load_i,
    input  logic [1:0]        priv_next_i,
    output logic [1:0]        cur_priv_o,
    output logic              grant_o,
    output logic              illegal_o
);
    csr_perm_pkg::lvl_e     cur_lvl;
    csr_perm_pkg::lvl_e     min_lvl;
    logic                   read_only;
    csr_perm_pkg::verdict_t verdict;

    csr_priv_state u_priv (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (priv_load_i),
        .next_i (priv_next_i),
        .lvl_o  (cur_lvl)
    );

    csr_field_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i      (csr_addr_i),
        .read_only_o (read_only),
        .min_lvl_o   (min_lvl)
    );

    csr_verdict u_judge (
        .valid_i     (valid_i),
        .rd_en_i     (rd_en_i),
        .wr_en_i     (wr_en_i),
        .setclr_i    (setclr_i),
        .src_zero_i  (src_zero_i),
        .impl_i      (impl_i),
        .read_only_i (read_only),
        .min_lvl_i   (min_lvl),
        .cur_lvl_i   (cur_lvl),
        .verdict_o   (verdict)
    );

    // Expose the held level.
    always_comb cur_priv_o = cur_lvl;

    generate
        if (REG_OUT) begin : g_reg
            csr_perm_pkg::verdict_t verdict_q;
            // Pipeline register for the verdict, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n) verdict_q <= '0;
                else        verdict_q <= verdict;
            end
            // Drive outputs from the register.
            always_comb begin
                grant_o   = verdict_q.grant;
                illegal_o = verdict_q.illegal;
            end
        end else begin : g_comb
            // Drive outputs straight from the decision logic.
            always_comb begin
                grant_o   = verdict.grant;
                illegal_o = verdict.illegal;
            end
        end
    endgenerate
endmodule

// File: rtl/csr_perm_check_sva.sv
// Property checker for csr_perm_check, attached by bind below.
// Assumes the registered variant for the timing properties.
module csr_perm_check_sva #(
    parameter int ADDR_W  = 12,
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic [ADDR_W-1:0] csr_addr_i,
    input logic              rd_en_i,
    input logic              wr_en_i,
    input logic              setclr_i,
    input logic              src_zero_i,
    input logic              impl_i,
    input logic              priv_load_i,
    input logic [1:0]        priv_next_i,
    input logic [1:0]        cur_priv_o,
    input logic              grant_o,
    input logic              illegal_o
);
    logic armed;

    // Marks cycles that have a full cycle of post-reset history.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R8
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_o && illegal_o));

    // R1
    reset_lvl_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (cur_priv_o == 2'd3 && !grant_o && !illegal_o));

    // R9
    lvl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(priv_load_i) |-> cur_priv_o == $past(priv_next_i));

    generate
        if (REG_OUT) begin : g_timed
            // R2
            idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
                armed && $past(!valid_i || !(rd_en_i || wr_en_i)) |-> !grant_o && !illegal_o);

            // R3
            low_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
                armed && $past(valid_i && (rd_en_i || wr_en_i)
                    && cur_priv_o < csr_addr_i[ADDR_W-3:ADDR_W-4]) |-> illegal_o);

            // R5
            ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
                armed && $past(valid_i && wr_en_i && !(setclr_i && src_zero_i)
                    && csr_addr_i[ADDR_W-1:ADDR_W-2] == 2'b11) |-> illegal_o);

            // R7
            unimpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
                armed && $past(valid_i && (rd_en_i || wr_en_i) && !impl_i) |-> illegal_o);
        end
    endgenerate
endmodule

bind csr_perm_check csr_perm_check_sva #(.ADDR_W(ADDR_W), .REG_OUT(REG_OUT)) u_sva (.*);

// File: tb/csr_perm_check_tb.sv
// Directed bench for csr_perm_check: one task per scenario, each checking its own results.
module csr_perm_check_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [11:0] csr_addr_i = '0;
    logic        rd_en_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic        setclr_i = 1'b0;
    logic        src_zero_i = 1'b0;
    logic        impl_i = 1'b0;
    logic        priv_load_i = 1'b0;
    logic [1:0]  priv_next_i = '0;
    logic [1:0]  cur_priv_o;
    logic        grant_o;
    logic        illegal_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    csr_perm_check dut_i (.*);

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {priv,grant,illegal} actual %b expected %b", req, act, exp);
        end
    endtask

    // Present one access for a cycle and compare the verdict one edge later.
    task automatic access(input string req, input logic [11:0] a, input logic v,
                          input logic rd, input logic wr, input logic sc, input logic sz,
                          input logic im, input logic eg, input logic ei);
        @(negedge clk);
        valid_i = v; csr_addr_i = a; rd_en_i = rd; wr_en_i = wr;
        setclr_i = sc; src_zero_i = sz; impl_i = im;
        @(negedge clk);
        valid_i = 0; rd_en_i = 0; wr_en_i = 0; setclr_i = 0; src_zero_i = 0;
        check(req, {1'b0, grant_o, illegal_o}, {1'b0, eg, ei});
    endtask

    task automatic set_priv(input logic [1:0] p);
        @(negedge clk);
        priv_load_i = 1; priv_next_i = p;
        @(negedge clk);
        priv_load_i = 0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1", {cur_priv_o, grant_o, illegal_o}, {2'd3, 1'b0, 1'b0});
    endtask

    task automatic t_idle;
        access("R2 no valid", 12'h300, 0, 1, 1, 0, 0, 1, 0, 0);
        access("R2 no rd/wr", 12'h300, 1, 0, 0, 0, 0, 0, 0, 0);
    endtask

    // All current/minimum level pairings, reading an implemented read/write register.
    task automatic t_levels;
        for (int p = 0; p < 4; p++) begin
            set_priv(p[1:0]);
            check("R9 load", {cur_priv_o, 1'b0}, {p[1:0], 1'b0});
            for (int m = 0; m < 4; m++) begin
                logic ok;
                ok = (p >= m);
                access(ok ? "R4 level ok" : "R3 level low", {2'b00, m[1:0], 8'h40},
                       1, 1, 0, 0, 0, 1, ok, !ok);
            end
        end
        set_priv(2'd3);
    endtask

    task automatic t_ro;
        access("R5 ro write",   12'hC00, 1, 1, 1, 0, 0, 1, 0, 1);
        access("R5 ro read",    12'hF14, 1, 1, 0, 0, 0, 1, 1, 0);
        access("R5 rw write",   12'h8C0, 1, 0, 1, 0, 0, 1, 1, 0);
        access("R5 ro set nz",  12'hF11, 1, 1, 1, 1, 0, 1, 0, 1);
        access("R6 ro set z",   12'hF11, 1, 1, 1, 1, 1, 1, 1, 0);
        access("R6 plain wr z", 12'hF11, 1, 1, 1, 0, 1, 1, 0, 1);
    endtask

    task automatic t_unimpl;
        access("R7 read",  12'h300, 1, 1, 0, 0, 0, 0, 0, 1);
        access("R7 write", 12'h000, 1, 0, 1, 0, 0, 0, 0, 1);
    endtask

    // Reload to User in the same cycle as a Machine-level access.
    task automatic t_same_cycle;
        @(negedge clk);
        priv_load_i = 1; priv_next_i = 2'd0;
        valid_i = 1; csr_addr_i = 12'h340; rd_en_i = 1; impl_i = 1;
        @(negedge clk);
        priv_load_i = 0; valid_i = 0; rd_en_i = 0;
        check("R9 old level used", {cur_priv_o, grant_o, illegal_o}, {2'd0, 1'b1, 1'b0});
        access("R9 new level used", 12'h340, 1, 1, 0, 0, 0, 1, 0, 1);
        set_priv(2'd3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_idle();
        t_levels();
        t_ro();
        t_unimpl();
        t_same_cycle();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule